// File: doc/BRIEF.md
# Latched-Address Video RAM Port

This block connects an 8-bit CPU bus to a byte-wide video RAM. It offers two ways in. A direct window covers CPU addresses with bit 15 clear. The top RAM address bit of that window comes from a bank bit held in a high address latch. An indirect data port reaches any byte of the RAM through the full address held in the high and low latches. Software loads the latches once and then streams pixels through a single register.

The block has one build-time option, the write mask. When the option is on, every write to the RAM merges the new byte into the stored byte, bit by bit, under a mask register. This lets software change a few pixels of a byte without reading it first. Each merge is a read-modify-write, so the block drops its ready output for one cycle after every write. When the option is off, every write stores the byte as given and the mask register does not exist.

The RAM address width is a parameter, `AW`, with a default of 11 and a maximum of 16. The high latch holds `AW-8` bits, and its top bit is the bank bit, which is data bit 7 when `AW` is 16. The window offset is the low `AW-1` bits of the CPU address, so the window aliases when `AW` is below 16.

Top module: `vram_latch_port`

## Requirements
- R1: During and after a synchronous reset, the high latch, the low latch and the mask are all zero. `cpu_ready` reads 1 and `cpu_rvalid` reads 0.
- R2: A CPU access with address bit 15 clear reaches the RAM byte at {bank bit, cpu_addr[AW-2:0]}. The bank bit is the top bit of the high latch, which is data bit AW-9 of the byte written to it.
- R3: The register page covers CPU addresses 0x9400 to 0x97FF, and only cpu_addr[1:0] select within it. The selections are:
  - 00: the data port
  - 01: the mask register
  - 10: the high latch, which keeps data bits [AW-9:0]
  - 11: the low latch, which keeps all 8 bits
- R4: A read or write of the data port reaches the RAM byte at {high latch, low latch}.
- R5: A read strobe to the window or to the data port raises `cpu_rvalid` on the next cycle, together with the stored byte. The byte is never masked. A read of a write-only register returns 0x00 with `cpu_rvalid`, and `cpu_rvalid` lasts one cycle.
- R6: With MASK_EN=1, a write through either path stores (old AND NOT mask) OR (new AND mask).
- R7: With MASK_EN=1, `cpu_ready` is low for exactly the one cycle after a write strobe. A write issued as soon as `cpu_ready` returns sees the merged value of the write before it.
- R8: With MASK_EN=0, writes store the data unchanged, writes to the mask register have no effect, and `cpu_ready` stays high.
- R9: An access with bit 15 set that falls outside the register page changes no RAM byte and no latch, and it raises no `cpu_rvalid`.
- R10: With MASK_EN=1 and the mask still at its reset value, a write leaves the RAM byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| cpu_ready | output | 1 | Low while a masked write is being merged |

## Verification
The assertions assume that the CPU issues no strobe while `cpu_ready` is low. This matters because the merge holds the captured address and data for its second cycle and cannot take a new request. The bench always waits for `cpu_ready` before its next strobe, and it drives one strobe at a time for a single cycle. A plain instance and a masked instance share the same bus. The bench therefore paces every access by the masked instance, and it compares each read against two separately derived expected bytes.

// File: rtl/vram_pkg.sv
package vram_pkg;

    // Decoded kind of one CPU access
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WIN,
        ACC_PORT,
        ACC_MASK,
        ACC_HI,
        ACC_LO
    } acc_e;

    // Upper six address bits of the register page (0x9400..0x97FF)
    localparam logic [5:0] REG_PAGE = 6'b100101;

    // Strobes produced by the decoder for the rest of the block
    typedef struct packed {
        logic ram_wr;
        logic ram_rd;
        logic sel_port;
        logic hi_we;
        logic lo_we;
        logic mask_we;
        logic reg_rd;
    } strobe_t;

    function automatic acc_e classify(input logic [15:0] a);
        acc_e k;
        if (!a[15]) begin
            k = ACC_WIN;
        end else if (a[15:10] != REG_PAGE) begin
            k = ACC_NONE;
        end else begin
            case (a[1:0])
                2'b00:   k = ACC_PORT;
                2'b01:   k = ACC_MASK;
                2'b10:   k = ACC_HI;
                default: k = ACC_LO;
            endcase
        end
        return k;
    endfunction

    // Bitwise merge: where m is set take nw, elsewhere keep old
    function automatic logic [7:0] merge(input logic [7:0] old,
                                         input logic [7:0] nw,
                                         input logic [7:0] m);
        return (old & ~m) | (nw & m);
    endfunction

endpackage

// File: rtl/vram_decode.sv
module vram_decode
    import vram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [15:0]   cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic          ready,
    output strobe_t       stb,
    output logic [AW-2:0] win_off
);
    acc_e kind;
    logic wr_ok;
    logic rd_ok;

    assign kind    = classify(cpu_addr);
    assign wr_ok   = cpu_wr && ready;
    assign rd_ok   = cpu_rd && ready;
    assign win_off = cpu_addr[AW-2:0];

    always_comb begin
        stb          = '0;
        stb.sel_port = (kind == ACC_PORT);
        stb.ram_wr   = wr_ok && (kind == ACC_WIN || kind == ACC_PORT);
        stb.ram_rd   = rd_ok && (kind == ACC_WIN || kind == ACC_PORT);
        stb.hi_we    = wr_ok && (kind == ACC_HI);
        stb.lo_we    = wr_ok && (kind == ACC_LO);
        stb.mask_we  = wr_ok && (kind == ACC_MASK);
        stb.reg_rd   = rd_ok && (kind == ACC_MASK || kind == ACC_HI || kind == ACC_LO);
    end
endmodule

// File: rtl/vram_regs.sv
module vram_regs #(
    parameter int HI_W    = 3,
    parameter bit MASK_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hi_we,
    input  logic            lo_we,
    input  logic            mask_we,
    input  logic [7:0]      wdata,
    output logic [HI_W-1:0] hi_q,
    output logic [7:0]      lo_q,
    output logic [7:0]      mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we) hi_q <= wdata[HI_W-1:0];
            if (lo_we) lo_q <= wdata;
        end
    end

    // R3: the high latch moves only in the cycle after its own write strobe
    assert_hi_only_on_write_R3: assert property (@(posedge clk) disable iff (rst)
        (hi_q != $past(hi_q)) |-> $past(hi_we));

    generate
        if (MASK_EN) begin : g_mask
            always_ff @(posedge clk) begin
                if (rst)          mask_q <= '0;
                else if (mask_we) mask_q <= wdata;
            end
        end else begin : g_nomask
            logic unused_mask_we;
            assign unused_mask_we = mask_we;
            assign mask_q = 8'hFF;
        end
    endgenerate
endmodule

// File: rtl/vram_store.sv
module vram_store
    import vram_pkg::*;
#(
    parameter int AW      = 11,
    parameter bit MASK_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    mask,
    output logic          busy,
    output logic [7:0]    rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // One synchronous read port, shared by CPU reads and the merge fetch
    always_ff @(posedge clk) begin
        if ((rd_en || wr_en) && !busy) rd_q <= mem[addr];
    end

    generate
        if (MASK_EN) begin : g_rmw
            logic          pend;
            logic [AW-1:0] p_addr;
            logic [7:0]    p_data;
            logic [7:0]    p_mask;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend <= 1'b0;
                end else begin
                    pend <= wr_en && !pend;
                end
                if (wr_en && !pend) begin
                    p_addr <= addr;
                    p_data <= wdata;
                    p_mask <= mask;
                end
            end

            always_ff @(posedge clk) begin
                if (pend) mem[p_addr] <= merge(rd_q, p_data, p_mask);
            end

            assign busy = pend;

            // R7: the merge occupies a single cycle
            assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
                busy |=> !busy);
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (wr_en) mem[addr] <= merge(8'h00, wdata, mask);
            end
            assign busy = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/vram_latch_port.sv
module vram_latch_port
    import vram_pkg::*;
#(
    parameter int AW      = 11,
    parameter bit MASK_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_rvalid,
    output logic        cpu_ready
);
    localparam int HI_W = AW - 8;

    strobe_t         stb;
    logic [AW-2:0]   win_off;
    logic [HI_W-1:0] hi_q;
    logic [7:0]      lo_q;
    logic [7:0]      mask_q;
    logic [AW-1:0]   ram_addr;
    logic            busy;
    logic [7:0]      rd_q;
    logic            rvalid_q;
    logic            zero_q;

    vram_decode #(.AW(AW)) u_decode (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .ready    (cpu_ready),
        .stb      (stb),
        .win_off  (win_off)
    );

    vram_regs #(.HI_W(HI_W), .MASK_EN(MASK_EN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .hi_we   (stb.hi_we),
        .lo_we   (stb.lo_we),
        .mask_we (stb.mask_we),
        .wdata   (cpu_wdata),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .mask_q  (mask_q)
    );

    // Indirect port uses the whole latch; the window takes only the bank bit
    assign ram_addr = stb.sel_port ? {hi_q, lo_q} : {hi_q[HI_W-1], win_off};

    vram_store #(.AW(AW), .MASK_EN(MASK_EN)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (stb.ram_wr),
        .rd_en (stb.ram_rd),
        .addr  (ram_addr),
        .wdata (cpu_wdata),
        .mask  (mask_q),
        .busy  (busy),
        .rd_q  (rd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            zero_q   <= 1'b0;
        end else begin
            rvalid_q <= stb.ram_rd || stb.reg_rd;
            zero_q   <= stb.reg_rd;
        end
    end

    assign cpu_ready  = !busy;
    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = zero_q ? 8'h00 : rd_q;

    // R7: the bus keeps quiet while a merge is in flight
    assert_idle_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |-> !(cpu_wr || cpu_rd));

    // R5: a window read is answered on the next cycle
    assert_rvalid_follows_read_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_ready && !cpu_addr[15]) |=> cpu_rvalid);

    // R9: valid data never appears without a preceding read strobe
    assert_rvalid_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> $past(cpu_rd));
endmodule

// File: tb/vram_latch_port_tb.sv
module vram_latch_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  m_rdata, p_rdata;
    logic        m_rvalid, p_rvalid, m_ready, p_ready;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vram_latch_port #(.AW(11), .MASK_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd),
        .cpu_wdata(wdata), .cpu_rdata(m_rdata), .cpu_rvalid(m_rvalid), .cpu_ready(m_ready)
    );

    vram_latch_port #(.AW(11), .MASK_EN(1'b0)) u_plain (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wr(wr), .cpu_rd(rd),
        .cpu_wdata(wdata), .cpu_rdata(p_rdata), .cpu_rvalid(p_rvalid), .cpu_ready(p_ready)
    );

    typedef struct packed {
        logic        is_wr;
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  exp_m;
        logic [7:0]  exp_p;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h9401, 8'hFF, 8'h00, 8'h00, 4'd6},  // R6 full mask
        '{1'b1, 16'h9402, 8'h00, 8'h00, 8'h00, 4'd3},  // R3 bank 0
        '{1'b1, 16'h0000, 8'h5A, 8'h00, 8'h00, 4'd2},
        '{1'b1, 16'h0005, 8'hA5, 8'h00, 8'h00, 4'd2},
        '{1'b0, 16'h0005, 8'h00, 8'hA5, 8'hA5, 4'd2},  // R2 bank 0
        '{1'b1, 16'h9402, 8'h04, 8'h00, 8'h00, 4'd3},  // bank bit set
        '{1'b1, 16'h0005, 8'h3C, 8'h00, 8'h00, 4'd2},
        '{1'b0, 16'h0005, 8'h00, 8'h3C, 8'h3C, 4'd2},  // R2 bank 1
        '{1'b1, 16'h9402, 8'h00, 8'h00, 8'h00, 4'd2},
        '{1'b0, 16'h0005, 8'h00, 8'hA5, 8'hA5, 4'd2},  // R2 bank 0 kept
        '{1'b1, 16'h9402, 8'h04, 8'h00, 8'h00, 4'd4},
        '{1'b1, 16'h9403, 8'h05, 8'h00, 8'h00, 4'd4},
        '{1'b0, 16'h9400, 8'h00, 8'h3C, 8'h3C, 4'd4},  // R4 port = 0x405
        '{1'b1, 16'h9400, 8'hC3, 8'h00, 8'h00, 4'd4},
        '{1'b0, 16'h0005, 8'h00, 8'hC3, 8'hC3, 4'd4},  // R4 port write seen
        '{1'b1, 16'h9401, 8'h0F, 8'h00, 8'h00, 4'd6},
        '{1'b1, 16'h0005, 8'hAA, 8'h00, 8'h00, 4'd6},
        '{1'b0, 16'h0005, 8'h00, 8'hCA, 8'hAA, 4'd6},  // R6 R8 window merge
        '{1'b1, 16'h0005, 8'h55, 8'h00, 8'h00, 4'd7},
        '{1'b1, 16'h0005, 8'hF0, 8'h00, 8'h00, 4'd7},
        '{1'b0, 16'h0005, 8'h00, 8'hC0, 8'hF0, 4'd7},  // R7 back-to-back
        '{1'b1, 16'h9401, 8'h3C, 8'h00, 8'h00, 4'd6},
        '{1'b1, 16'h9400, 8'hFF, 8'h00, 8'h00, 4'd6},
        '{1'b0, 16'h9400, 8'h00, 8'hFC, 8'hFF, 4'd6},  // R6 port merge
        '{1'b1, 16'h97FF, 8'h06, 8'h00, 8'h00, 4'd3},  // R3 mirrored low latch
        '{1'b1, 16'h95F9, 8'hFF, 8'h00, 8'h00, 4'd3},  // R3 mirrored mask
        '{1'b1, 16'h9400, 8'h11, 8'h00, 8'h00, 4'd3},
        '{1'b0, 16'h0006, 8'h00, 8'h11, 8'h11, 4'd3},  // R3 port now 0x406
        '{1'b0, 16'h97F8, 8'h00, 8'h11, 8'h11, 4'd3},  // R3 mirrored port
        '{1'b0, 16'h9402, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 write-only reads 0
        '{1'b1, 16'h8000, 8'h77, 8'h00, 8'h00, 4'd9},  // R9 outside page
        '{1'b0, 16'h9400, 8'h00, 8'h11, 8'h11, 4'd9}   // R9 nothing moved
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        while (!m_ready) @(negedge clk);
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] rm, output logic [7:0] rp,
                         output logic vm, output logic vp);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        rm = m_rdata; rp = p_rdata; vm = m_rvalid; vp = p_rvalid;
    endtask

    initial begin
        logic [7:0] rm, rp;
        logic vm, vp;
        repeat (3) @(negedge clk);
        // R1 reset state of handshake outputs
        chk("R1 ready", {7'd0, m_ready}, 8'd1);
        chk("R1 rvalid", {7'd0, m_rvalid}, 8'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                do_wr(VEC[i].a, VEC[i].d);
            end else begin
                do_rd(VEC[i].a, rm, rp, vm, vp);
                chk($sformatf("R%0d masked read vec %0d", VEC[i].req, i), rm, VEC[i].exp_m);
                chk($sformatf("R%0d plain read vec %0d", VEC[i].req, i), rp, VEC[i].exp_p);
                chk($sformatf("R5 rvalid vec %0d", i), {6'd0, vm, vp}, 8'h03);
            end
        end

        // R9 no rvalid for a read outside the page
        do_rd(16'h9800, rm, rp, vm, vp);
        chk("R9 no rvalid", {6'd0, vm, vp}, 8'h00);

        // R5 rvalid lasts one cycle
        do_rd(16'h0006, rm, rp, vm, vp);
        @(negedge clk);
        chk("R5 rvalid drops", {6'd0, m_rvalid, p_rvalid}, 8'h00);

        // R7 R8 ready timing around a write
        @(negedge clk);
        addr = 16'h0007; wdata = 8'h01; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        chk("R7 ready low after write", {7'd0, m_ready}, 8'd0);
        chk("R8 plain ready stays high", {7'd0, p_ready}, 8'd1);
        @(negedge clk);
        chk("R7 ready back", {7'd0, m_ready}, 8'd1);

        // R1 R10 reset clears latches and mask, RAM keeps contents
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready in reset", {7'd0, m_ready}, 8'd1);
        rst = 1'b0;
        do_rd(16'h9400, rm, rp, vm, vp);   // port at {0,0}
        chk("R1 latches cleared masked", rm, 8'h5A);
        chk("R1 latches cleared plain", rp, 8'h5A);
        do_wr(16'h0000, 8'h99);
        do_rd(16'h0000, rm, rp, vm, vp);
        chk("R10 zero mask keeps byte", rm, 8'h5A);
        chk("R8 plain writes unchanged", rp, 8'h99);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule